// File: doc/BRIEF.md
# Oscillator Halt Status Register

This block keeps the status and control bits of a real-time-clock peripheral and watches its 32.768 kHz crystal clock for a stop. A fast, always-running reference clock samples the crystal clock through a two-flop synchronizer. A counter measures how many reference cycles pass between crystal rising edges. If the gap grows past a programmable limit while chip-enable is low, a sticky halt flag is raised.

The halt flag is set at power-on, so software can tell when the time data cannot be trusted. Software clears the flag by writing zero to it. While the flag is set, the adjustment register and both control registers are held at zero. The interrupt output is held inactive and the 32 kHz pass-through output is enabled. The host reaches all four registers through a simple address, write-data, write-enable and read-data port in the reference clock domain.

Top module: `osc_halt_status`

## Requirements
- R1: After reset the halt flag (status register, address 3, bit 0) reads 1. Addresses 0, 1 and 2 read 0.
- R2: With chip_en low, if no rising edge of xtal_clk is seen for more than TIMEOUT reference cycles, the halt flag becomes 1. It stays 1 after xtal_clk toggles again.
- R3: A write to address 3 with wdata bit 0 equal to 0 clears the halt flag. It also restarts the gap count, so a crystal that is still stopped sets the flag again after the timeout.
- R4: A write to address 3 with wdata bit 0 equal to 1 does not change the halt flag.
- R5: While the halt flag is 1, the adjustment register (address 0), control 1 (address 1) and control 2 (address 2) read 0, and writes to them are ignored.
- R6: irq_out equals irq_src AND control 1 bit 0, and it is forced to 0 while the halt flag is 1.
- R7: While chip_en is high, the halt flag cannot become 1, however long xtal_clk is stopped.
- R8: clk32_out follows xtal_clk unless control 1 bit 4 and control 2 bit 3 are both 1. In that case it is held at 1.
- R9: Control 2 bit 5 is a free read/write scratch bit, and it is cleared when the halt flag sets.
- R10: When a halt is detected in the same cycle as a write of 0 to the flag, the flag ends up set.
- R11: Registers map as adjustment=0, control 1=1, control 2=2 and status=3. Status bits 7:1 read 0. rdata shows the addressed register combinationally, and a write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_clk | input | 1 | 32.768 kHz crystal clock, asynchronous to clk |
| chip_en | input | 1 | Chip-enable; high blocks halt detection |
| irq_src | input | 1 | Interrupt request from the timekeeping logic |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data of the addressed register |
| irq_out | output | 1 | Interrupt output, active high |
| clk32_out | output | 1 | Gated 32 kHz clock output, idles high |

## Verification
A gap counter that never saturates would hide a stopped crystal for good. A counter that resets too eagerly would raise the flag while the crystal is healthy. Either fault shows up in the status read within TIMEOUT plus about three reference cycles. A flag that is wrongly clear lets control writes stick, so irq_out and clk32_out depart from the model on the very next cycle. The bench compares rdata, irq_out and clk32_out against a behavioural model on every clock, so any such error is caught in the first cycle it reaches a port.

// File: rtl/osc_halt_status.sv
module osc_halt_status #(
  parameter int TIMEOUT = 64,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_clk,
  input  logic          chip_en,
  input  logic          irq_src,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_out,
  output logic          clk32_out
);
  localparam int CW          = $clog2(TIMEOUT + 2);
  localparam int IRQ_EN_BIT  = 0;
  localparam int CLKOFF1_BIT = 4;
  localparam int CLKOFF2_BIT = 3;
  localparam logic [1:0] A_ADJ  = 2'd0;
  localparam logic [1:0] A_CTL1 = 2'd1;
  localparam logic [1:0] A_CTL2 = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  logic [2:0]    xs;
  logic [CW-1:0] gap;
  logic          halt_q;
  logic [DW-1:0] adj_q, ctl1_q, ctl2_q;

  wire rise     = xs[1] & ~xs[2];
  wire clr_wr   = wr_en & (addr == A_STAT) & ~wdata[0];
  wire over     = gap > CW'(TIMEOUT);
  wire halt_evt = ~chip_en & over;
  wire hold     = halt_evt | halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) xs <= '0;
    else        xs <= {xs[1:0], xtal_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gap <= '0;
    else if (rise || clr_wr) gap <= '0;
    else if (!over)          gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        halt_q <= 1'b1;
    else if (halt_evt) halt_q <= 1'b1;
    else if (clr_wr)   halt_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      adj_q  <= '0;
      ctl1_q <= '0;
      ctl2_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_ADJ:   adj_q  <= wdata;
        A_CTL1:  ctl1_q <= wdata;
        A_CTL2:  ctl2_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_ADJ:   rdata = adj_q;
      A_CTL1:  rdata = ctl1_q;
      A_CTL2:  rdata = ctl2_q;
      default: rdata = {{(DW-1){1'b0}}, halt_q};
    endcase
  end

  assign irq_out   = irq_src & ctl1_q[IRQ_EN_BIT] & ~halt_q;
  assign clk32_out = (ctl1_q[CLKOFF1_BIT] & ctl2_q[CLKOFF2_BIT]) ? 1'b1 : xtal_clk;
endmodule

// File: rtl/osc_halt_status_chk.sv
module osc_halt_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic          xtal_clk,
  input logic          halt_q,
  input logic [DW-1:0] adj_q,
  input logic [DW-1:0] ctl1_q,
  input logic [DW-1:0] ctl2_q,
  input logic          irq_out,
  input logic          clk32_out
);
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !(wr_en && addr == 2'd3 && !wdata[0])) |=> halt_q);

  a_r4_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && wr_en && addr == 2'd3 && wdata[0]) |=> halt_q);

  a_r5_regs_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (adj_q == '0 && ctl1_q == '0 && ctl2_q == '0));

  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !irq_out);

  a_r7_ce_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !halt_q) |=> !halt_q);

  a_r8_clk_passes: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (clk32_out == xtal_clk));
endmodule

bind osc_halt_status osc_halt_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .xtal_clk(xtal_clk), .halt_q(halt_q), .adj_q(adj_q),
  .ctl1_q(ctl1_q), .ctl2_q(ctl2_q), .irq_out(irq_out), .clk32_out(clk32_out)
);

// File: tb/osc_halt_status_tb.sv
module osc_halt_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 12;
  localparam int XH = 3;

  logic clk = 0, rst_n = 0, xtal_clk = 0, chip_en = 0, irq_src = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq_out, clk32_out;

  int total = 0, fails = 0;
  bit xrun = 1;
  int xc = 0;

  int m_s1 = 0, m_s2 = 0, m_s3 = 0, m_cnt = 0;
  bit m_flag = 1;
  logic [7:0] m_adj = 0, m_c1 = 0, m_c2 = 0;

  osc_halt_status #(.TIMEOUT(TO), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .chip_en(chip_en),
    .irq_src(irq_src), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_out(irq_out), .clk32_out(clk32_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (xrun) begin
    xc++;
    if (xc >= XH) begin xtal_clk = ~xtal_clk; xc = 0; end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_adj;
      2'd1: return m_c1;
      2'd2: return m_c2;
      default: return {7'b0, m_flag};
    endcase
  endfunction

  always @(posedge clk) begin
    bit rise, clr, evt;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_flag = 1;
      m_adj = 0; m_c1 = 0; m_c2 = 0;
    end else begin
      rise = (m_s2 == 1) && (m_s3 == 0);
      clr  = wr_en && addr == 2'd3 && !wdata[0];
      evt  = !chip_en && m_cnt > TO;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = xtal_clk;
      if (rise || clr) m_cnt = 0;
      else if (m_cnt <= TO) m_cnt++;
      if (evt || m_flag) begin
        m_adj = 0; m_c1 = 0; m_c2 = 0;
      end else if (wr_en) begin
        if (addr == 2'd0) m_adj = wdata;
        if (addr == 2'd1) m_c1 = wdata;
        if (addr == 2'd2) m_c2 = wdata;
      end
      if (evt) m_flag = 1;
      else if (clr) m_flag = 0;
    end
    #(CLK_PERIOD/4);
    chk("R11 rdata", rdata, m_read(addr));
    chk("R6 irq_out", irq_out, irq_src & m_c1[0] & !m_flag);
    chk("R8 clk32_out", clk32_out, (m_c1[4] & m_c2[3]) ? 1'b1 : xtal_clk);
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3, 8'h01, "R1 flag after reset");
    rd(0, 8'h00, "R1 adj after reset");
    rd(1, 8'h00, "R1 ctl1 after reset");
    rd(2, 8'h00, "R1 ctl2 after reset");

    wr(0, 8'h55);
    rd(0, 8'h00, "R5 write ignored while halted");

    wr(3, 8'h00);
    rd(3, 8'h00, "R3 flag cleared by write 0");
    wr(3, 8'h01);
    rd(3, 8'h00, "R4 write 1 has no effect");

    wr(0, 8'hA5);
    wr(1, 8'h11);
    wr(2, 8'h28);
    rd(0, 8'hA5, "R11 adj readback");
    rd(1, 8'h11, "R11 ctl1 readback");
    rd(2, 8'h28, "R9 scratch bit set");
    irq_src = 1;
    @(negedge clk); #1;
    chk("R6 irq follows source", irq_out, 1'b1);
    repeat (8) begin
      @(negedge clk); #1;
      chk("R8 output held high", clk32_out, 1'b1);
    end
    wr(2, 8'h20);
    repeat (8) @(negedge clk);

    chip_en = 1;
    xrun = 0;
    repeat (40) @(negedge clk);
    rd(3, 8'h00, "R7 no halt while chip_en high");
    rd(1, 8'h11, "R7 ctl1 kept while chip_en high");

    chip_en = 0;
    repeat (4) @(negedge clk);
    rd(3, 8'h01, "R2 halt detected");
    rd(2, 8'h00, "R9 scratch cleared by halt");
    rd(0, 8'h00, "R5 adj zero after halt");
    #1 chk("R6 irq forced low", irq_out, 1'b0);

    xrun = 1;
    repeat (30) @(negedge clk);
    rd(3, 8'h01, "R2 flag sticky after restart");

    xrun = 0;
    wr(3, 8'h00);
    rd(3, 8'h00, "R3 cleared with crystal stopped");
    do @(negedge clk); while (!(m_cnt > TO));
    addr = 3; wdata = 0; wr_en = 1;
    @(negedge clk); wr_en = 0; #1;
    chk("R10 halt wins over clear", rdata, 8'h01);

    wr(3, 8'h00);
    rd(3, 8'h00, "R3 clear again");
    repeat (TO + 6) @(negedge clk);
    rd(3, 8'h01, "R3 rearmed detector fires again");

    finish_run();
  end
endmodule